// File: doc/BRIEF.md
# NAND Page ECC-Skip Sequencer

This block follows the byte stream of a NAND page read in which the spare area is protected. It produces the enable that feeds the per-sector BCH remainder logic. Every sector byte asserts that enable. Spare bytes also assert it, except those that fall inside a programmable ECC window. The window holds the stored redundancy and may sit anywhere inside the spare region. The BCH arithmetic is not part of this block.

A page read starts with a DATA command. The block then counts the sector bytes, moves the sector index forward at each sector boundary, and counts the spare bytes. It pulses done after the last spare byte. A later USER command starts a second pass that accepts only the bytes of the ECC window, with the remainder enable held low. It pulses done again after the last window byte. A small decoder also reports how many remainder registers are relevant for the selected correction level.

Top module: `nand_ecc_skip_seq`

## Requirements
- R1: After reset (rst_ni low), rem_en_o, ecc_area_o and done_o are low and sector_o is 0. The block is idle.
- R2: A one-cycle data_cmd_i while idle starts a DATA pass in the next cycle. The pass accepts (sect_last_i+1) sectors followed by spare_size_i spare bytes. A sector is 512 bytes when sect_1k_i=0 and 1024 bytes when sect_1k_i=1.
- R3: rem_en_o is high exactly in the cycles where byte_vld_i is high and the current DATA-pass byte is a sector byte, or a spare byte outside the ECC window.
- R4: sector_o gives the index of the sector that holds the current byte. It advances after the last byte of each sector. It keeps the final index through the spare area and until the next DATA command.
- R5: The ECC window covers the spare offsets ecc_start_i through ecc_end_i, both included, with offset 0 being the first spare byte. ecc_area_o is high while the DATA pass is on a spare byte inside the window. ecc_start_i > ecc_end_i makes the window empty.
- R6: done_o is a single-cycle pulse. In a DATA pass it comes in the cycle after the last spare byte is accepted, or after the last sector byte when spare_size_i=0.
- R7: A user_cmd_i while idle starts a USER pass that accepts the window bytes from offset ecc_start_i up to ecc_end_i. During this pass ecc_area_o is high and rem_en_o is low. done_o pulses in the cycle after the byte at ecc_end_i. With an empty window, done_o pulses in the cycle after the command and no bytes are accepted.
- R8: data_cmd_i and user_cmd_i are ignored while a pass is active. If both are high in the same idle cycle, the DATA pass starts.
- R9: rem_regs_o maps bch_lvl_i as 0→1, 1→2, 2→4, 3→8, 4→12, and 5..7→12, for either sector size.
- R10: A cycle with byte_vld_i low does not advance any position. byte_vld_i while idle produces no enable, no window flag and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_cmd_i | input | 1 | Start a DATA pass (page plus spare) |
| user_cmd_i | input | 1 | Start a USER pass (ECC window only) |
| byte_vld_i | input | 1 | A NAND byte is present in this cycle |
| sect_1k_i | input | 1 | Sector size: 0 = 512 bytes, 1 = 1024 bytes |
| sect_last_i | input | SECT_W | Index of the last sector in the page |
| spare_size_i | input | SPARE_W | Spare area length in bytes |
| ecc_start_i | input | SPARE_W | First spare offset of the ECC window |
| ecc_end_i | input | SPARE_W | Last spare offset of the ECC window (included) |
| bch_lvl_i | input | 3 | Correction-level code |
| rem_en_o | output | 1 | Remainder computation enable for the current byte |
| ecc_area_o | output | 1 | Current byte lies in the ECC window |
| sector_o | output | SECT_W | Current sector index |
| done_o | output | 1 | End-of-pass pulse |
| rem_regs_o | output | 4 | Number of relevant remainder registers |

## Verification
The bench builds the block with MAX_SECTORS=8 and SPARE_W=8. This reaches pages of one to eight sectors of either size, spare areas up to 255 bytes, and windows placed at the first offset, at the last offset, over the whole spare, or inverted to empty. Because sector_o is three bits wide, an eight-sector page drives the index to its top value. The runs cover a zero-length spare, gaps in the byte strobe, commands injected in the middle of a pass, and a reset taken in the middle of a page.

// File: rtl/ecc_skip_pkg.sv
package ecc_skip_pkg;
  localparam int unsigned SECT_SMALL = 512;
  localparam int unsigned SECT_LARGE = 1024;
  localparam int unsigned BYTE_W     = $clog2(SECT_LARGE);
  localparam int unsigned LVL_W      = 3;
  localparam int unsigned REMCNT_W   = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SECT  = 2'd1,
    ST_SPARE = 2'd2,
    ST_USER  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/ecc_sect_track.sv
module ecc_sect_track
  import ecc_skip_pkg::*;
#(
  parameter int unsigned SECT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic              sect_1k_i,
  input  logic [SECT_W-1:0] sect_last_i,
  output logic [SECT_W-1:0] sector_o,
  output logic              page_end_o
);
  localparam logic [BYTE_W-1:0] LAST_S = BYTE_W'(SECT_SMALL - 1);
  localparam logic [BYTE_W-1:0] LAST_L = BYTE_W'(SECT_LARGE - 1);

  logic [BYTE_W-1:0] byte_q;
  logic [SECT_W-1:0] sect_q;
  logic              sect_end;

  assign sect_end   = (byte_q == (sect_1k_i ? LAST_L : LAST_S));
  assign page_end_o = sect_end && (sect_q == sect_last_i);
  assign sector_o   = sect_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      sect_q <= '0;
    end else if (clr_i) begin
      byte_q <= '0;
      sect_q <= '0;
    end else if (adv_i) begin
      if (sect_end) begin
        byte_q <= '0;
        // index holds on the last sector through the spare phase
        if (!page_end_o) sect_q <= sect_q + SECT_W'(1);
      end else begin
        byte_q <= byte_q + BYTE_W'(1);
      end
    end
  end
endmodule

// File: rtl/ecc_spare_win.sv
module ecc_spare_win #(
  parameter int unsigned SPARE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [SPARE_W-1:0] load_val_i,
  input  logic               inc_i,
  input  logic [SPARE_W-1:0] spare_size_i,
  input  logic [SPARE_W-1:0] win_start_i,
  input  logic [SPARE_W-1:0] win_end_i,
  output logic               in_win_o,
  output logic               win_empty_o,
  output logic               spare_last_o,
  output logic               win_last_o
);
  localparam logic [SPARE_W-1:0] ONE = SPARE_W'(1);

  logic [SPARE_W-1:0] off_q;

  assign win_empty_o  = (win_start_i > win_end_i);
  assign in_win_o     = !win_empty_o && (off_q >= win_start_i) && (off_q <= win_end_i);
  assign spare_last_o = (off_q == (spare_size_i - ONE));
  assign win_last_o   = (off_q == win_end_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= '0;
    else if (load_i) off_q <= load_val_i;
    else if (inc_i)  off_q <= off_q + ONE;
  end
endmodule

// File: rtl/ecc_rem_count.sv
module ecc_rem_count
  import ecc_skip_pkg::*;
(
  input  logic [LVL_W-1:0]    lvl_i,
  output logic [REMCNT_W-1:0] cnt_o
);
  always_comb begin
    case (lvl_i)
      3'd0:    cnt_o = REMCNT_W'(1);
      3'd1:    cnt_o = REMCNT_W'(2);
      3'd2:    cnt_o = REMCNT_W'(4);
      3'd3:    cnt_o = REMCNT_W'(8);
      default: cnt_o = REMCNT_W'(12);
    endcase
  end
endmodule

// File: rtl/nand_ecc_skip_seq.sv
module nand_ecc_skip_seq
  import ecc_skip_pkg::*;
#(
  parameter int unsigned MAX_SECTORS = 8,
  parameter int unsigned SPARE_W     = 8,
  localparam int unsigned SECT_W     = (MAX_SECTORS > 1) ? $clog2(MAX_SECTORS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                data_cmd_i,
  input  logic                user_cmd_i,
  input  logic                byte_vld_i,
  input  logic                sect_1k_i,
  input  logic [SECT_W-1:0]   sect_last_i,
  input  logic [SPARE_W-1:0]  spare_size_i,
  input  logic [SPARE_W-1:0]  ecc_start_i,
  input  logic [SPARE_W-1:0]  ecc_end_i,
  input  logic [LVL_W-1:0]    bch_lvl_i,
  output logic                rem_en_o,
  output logic                ecc_area_o,
  output logic [SECT_W-1:0]   sector_o,
  output logic                done_o,
  output logic [REMCNT_W-1:0] rem_regs_o
);
  seq_state_e         state_q, state_d;
  logic               done_q, done_d;
  logic               sect_clr, sect_adv, page_end;
  logic               off_load, off_inc;
  logic [SPARE_W-1:0] off_load_val;
  logic               in_win, win_empty, spare_last, win_last;

  ecc_sect_track #(.SECT_W(SECT_W)) u_sect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (sect_clr),
    .adv_i       (sect_adv),
    .sect_1k_i   (sect_1k_i),
    .sect_last_i (sect_last_i),
    .sector_o    (sector_o),
    .page_end_o  (page_end)
  );

  ecc_spare_win #(.SPARE_W(SPARE_W)) u_win (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (off_load),
    .load_val_i   (off_load_val),
    .inc_i        (off_inc),
    .spare_size_i (spare_size_i),
    .win_start_i  (ecc_start_i),
    .win_end_i    (ecc_end_i),
    .in_win_o     (in_win),
    .win_empty_o  (win_empty),
    .spare_last_o (spare_last),
    .win_last_o   (win_last)
  );

  ecc_rem_count u_rem (
    .lvl_i (bch_lvl_i),
    .cnt_o (rem_regs_o)
  );

  always_comb begin
    state_d      = state_q;
    done_d       = 1'b0;
    sect_clr     = 1'b0;
    sect_adv     = 1'b0;
    off_load     = 1'b0;
    off_load_val = '0;
    off_inc      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (data_cmd_i) begin
          state_d  = ST_SECT;
          sect_clr = 1'b1;
        end else if (user_cmd_i) begin
          if (win_empty) begin
            done_d = 1'b1;
          end else begin
            state_d      = ST_USER;
            off_load     = 1'b1;
            off_load_val = ecc_start_i;
          end
        end
      end
      ST_SECT: begin
        if (byte_vld_i) begin
          sect_adv = 1'b1;
          if (page_end) begin
            if (spare_size_i == '0) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end else begin
              state_d  = ST_SPARE;
              off_load = 1'b1;
            end
          end
        end
      end
      ST_SPARE: begin
        if (byte_vld_i) begin
          if (spare_last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            off_inc = 1'b1;
          end
        end
      end
      ST_USER: begin
        if (byte_vld_i) begin
          if (win_last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            off_inc = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  // enable qualifies the byte present in this cycle
  assign rem_en_o   = byte_vld_i &&
                      ((state_q == ST_SECT) || ((state_q == ST_SPARE) && !in_win));
  assign ecc_area_o = ((state_q == ST_SPARE) && in_win) || (state_q == ST_USER);
  assign done_o     = done_q;
endmodule

// File: rtl/ecc_skip_sva.sv
module ecc_skip_sva #(
  parameter int unsigned SECT_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_vld_i,
  input logic              rem_en_o,
  input logic              ecc_area_o,
  input logic              done_o,
  input logic [SECT_W-1:0] sector_o,
  input logic [3:0]        rem_regs_o
);
  AST_EN_NEEDS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i |-> !rem_en_o); // R3

  AST_EN_OUTSIDE_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_en_o |-> !ecc_area_o); // R5

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rem_en_o && !ecc_area_o)); // R7

  AST_SECT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sector_o != $past(sector_o)) |->
      ((sector_o == SECT_W'($past(sector_o) + 1'b1)) || (sector_o == '0))); // R4

  AST_REM_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_regs_o inside {4'd1, 4'd2, 4'd4, 4'd8, 4'd12}); // R9
endmodule

bind nand_ecc_skip_seq ecc_skip_sva #(.SECT_W(SECT_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .byte_vld_i (byte_vld_i),
  .rem_en_o   (rem_en_o),
  .ecc_area_o (ecc_area_o),
  .done_o     (done_o),
  .sector_o   (sector_o),
  .rem_regs_o (rem_regs_o)
);

// File: tb/nand_ecc_skip_seq_tb_top.sv
module nand_ecc_skip_seq_tb_top;
  localparam int SECT_W = 3;

  typedef struct packed {
    logic       s1k;
    logic [2:0] nsm1;
    logic [7:0] spare;
    logic [7:0] st;
    logic [7:0] en;
    logic       gap;
    logic       both;
  } pvec_t;

  localparam pvec_t PAGES [6] = '{
    '{1'b0, 3'd0, 8'd16, 8'd4,  8'd11, 1'b0, 1'b0},
    '{1'b1, 3'd1, 8'd32, 8'd0,  8'd31, 1'b1, 1'b0},
    '{1'b0, 3'd3, 8'd24, 8'd20, 8'd10, 1'b0, 1'b1},
    '{1'b0, 3'd1, 8'd0,  8'd0,  8'd3,  1'b1, 1'b0},
    '{1'b1, 3'd0, 8'd64, 8'd63, 8'd63, 1'b0, 1'b0},
    '{1'b0, 3'd7, 8'd8,  8'd0,  8'd0,  1'b1, 1'b0}
  };

  localparam int REM_EXP [8] = '{1, 2, 4, 8, 12, 12, 12, 12};

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              data_cmd = 1'b0, user_cmd = 1'b0, byte_vld = 1'b0, sect_1k = 1'b0;
  logic [SECT_W-1:0] sect_last = '0;
  logic [7:0]        spare_size = '0, ecc_start = '0, ecc_end = '0;
  logic [2:0]        bch_lvl = '0;
  logic              rem_en, ecc_area, done;
  logic [SECT_W-1:0] sector;
  logic [3:0]        rem_regs;
  int                checks = 0, errors = 0;
  bit                finished = 1'b0;

  always #5 clk = ~clk;

  nand_ecc_skip_seq #(.MAX_SECTORS(8), .SPARE_W(8)) dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .data_cmd_i (data_cmd), .user_cmd_i (user_cmd),
    .byte_vld_i (byte_vld), .sect_1k_i (sect_1k), .sect_last_i (sect_last),
    .spare_size_i (spare_size), .ecc_start_i (ecc_start), .ecc_end_i (ecc_end),
    .bch_lvl_i (bch_lvl), .rem_en_o (rem_en), .ecc_area_o (ecc_area),
    .sector_o (sector), .done_o (done), .rem_regs_o (rem_regs)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample 1 ns later
  task automatic send(input string req, input bit vld, input bit inj,
                      input bit exp_en, input bit exp_area, input int exp_sect);
    @(negedge clk);
    byte_vld = vld; data_cmd = inj; user_cmd = inj;
    #1;
    chk(req, "rem_en", rem_en, exp_en);
    chk("R5", "ecc_area", ecc_area, exp_area);
    if (exp_sect >= 0) chk("R4", "sector", sector, exp_sect);
    chk("R6", "done early", done, 0);
  endtask

  task automatic expect_done(input string req);
    @(negedge clk);
    byte_vld = 1'b0; data_cmd = 1'b0; user_cmd = 1'b0;
    #1;
    chk(req, "done", done, 1);
    @(negedge clk); #1;
    chk("R6", "done width", done, 0);
  endtask

  task automatic run_page(input pvec_t v);
    int idx = 0;
    int nb;
    bit inw;
    nb = v.s1k ? 1024 : 512;
    sect_1k = v.s1k; sect_last = v.nsm1; spare_size = v.spare;
    ecc_start = v.st; ecc_end = v.en;
    @(negedge clk);
    data_cmd = 1'b1; user_cmd = v.both; byte_vld = 1'b0;  // R8 priority when both
    for (int s = 0; s <= int'(v.nsm1); s++) begin
      for (int b = 0; b < nb; b++) begin
        if (v.gap && (idx % 97 == 5)) send("R10", 1'b0, 1'b0, 1'b0, 1'b0, s);
        // R8: commands injected at byte 100 must be ignored
        send((idx == 100 || (idx == 0 && v.both)) ? "R8" : "R3", 1'b1, idx == 100, 1'b1, 1'b0, s);
        idx++;
      end
    end
    for (int o = 0; o < int'(v.spare); o++) begin
      inw = (v.st <= v.en) && (o >= int'(v.st)) && (o <= int'(v.en));
      if (v.gap && (idx % 97 == 5)) send("R10", 1'b0, 1'b0, 1'b0, inw, int'(v.nsm1));
      send(idx == 100 ? "R8" : "R3", 1'b1, idx == 100, !inw, inw, int'(v.nsm1));
      idx++;
    end
    expect_done("R2");
    chk("R4", "sector held", sector, int'(v.nsm1));
  endtask

  task automatic run_user(input logic [7:0] st, input logic [7:0] en);
    ecc_start = st; ecc_end = en;
    @(negedge clk);
    user_cmd = 1'b1; byte_vld = 1'b0;
    if (st > en) begin
      @(negedge clk);
      user_cmd = 1'b0; #1;
      chk("R7", "empty done", done, 1);
      @(negedge clk); #1;
      chk("R7", "empty done width", done, 0);
    end else begin
      for (int o = int'(st); o <= int'(en); o++) begin
        if (o == int'(st)) send("R10", 1'b0, 1'b0, 1'b0, 1'b1, -1);
        send("R7", 1'b1, o == int'(st) + 1, 1'b0, 1'b1, -1);
      end
      expect_done("R7");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R6 watchdog act=0 exp=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    byte_vld = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "rem_en in reset", rem_en, 0);
    chk("R1", "ecc_area in reset", ecc_area, 0);
    chk("R1", "done in reset", done, 0);
    chk("R1", "sector in reset", sector, 0);
    @(negedge clk); rst_ni = 1'b1;

    // R10 idle strobes ignored
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); byte_vld = 1'b1; #1;
      chk("R10", "idle rem_en", rem_en, 0);
      chk("R10", "idle ecc_area", ecc_area, 0);
      chk("R10", "idle done", done, 0);
    end

    // R9 remainder count table
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      bch_lvl = 3'(i % 8); sect_1k = 1'(i / 8); #1;
      chk("R9", "rem_regs", rem_regs, REM_EXP[i % 8]);
    end

    // main vector walk, with user passes after each page
    for (int p = 0; p < 6; p++) begin
      run_page(PAGES[p]);
      run_user(PAGES[p].st, PAGES[p].en);
    end

    // reset in the middle of a page
    sect_1k = 1'b0; sect_last = 3'd1; spare_size = 8'd16; ecc_start = 8'd2; ecc_end = 8'd5;
    @(negedge clk); data_cmd = 1'b1;
    for (int b = 0; b < 600; b++) send("R3", 1'b1, 1'b0, 1'b1, 1'b0, b / 512);
    @(negedge clk); rst_ni = 1'b0; byte_vld = 1'b1; #1;
    chk("R1", "mid reset rem_en", rem_en, 0);
    chk("R1", "mid reset sector", sector, 0);
    @(negedge clk); rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk("R1", "idle after reset", rem_en, 0);
    end
    run_page(PAGES[0]);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule